// File: doc/BRIEF.md
# Dual-Mode Serial Clock Rate Generator

This block derives the serial clock of a SPI master from the module clock. A 13-bit control word selects one of two ways to divide. In the linear way, an 8-bit count n gives a serial clock of module clock / (2·(n+1)). In the power-of-two way, a 4-bit exponent m gives module clock / 2^(m+1). Both ways produce a 50% duty cycle, because the output toggles after every half period of module clocks.

Software writes the control word. The shift engine raises a run request for as long as a transfer lasts. While a transfer runs, the block counts half periods and toggles the serial clock. It also emits a one-cycle strobe with each edge: one for the edge that leaves the idle level and one for the edge that returns to it. The shift engine launches and captures data on these strobes. Between transfers the serial clock rests at the polarity level the shift engine supplies.

A control word written during a transfer is held back until the transfer ends, so a running serial clock never changes its period.

Top module: `sclk_rate_gen`

## Requirements
- R1: While rst_n is low, sclk, sclk_lead and sclk_trail are all 0, and the applied control word clears to 0.
- R2: When control bit 12 is 1 (linear), with n = bits 7:0, sclk stays high for n+1 module clocks and low for n+1 module clocks. The period is therefore 2·(n+1).
- R3: When control bit 12 is 0 (power-of-two), with m = bits 11:8, each sclk level lasts 2^m module clocks. The period is therefore 2^(m+1). The same n and m fields give different periods depending only on bit 12.
- R4: In linear mode with n = 0, sclk toggles on every module clock, giving a period of 2.
- R5: sclk_lead is high for exactly the one cycle in which sclk has just moved away from the idle level. sclk_trail is high for exactly the one cycle in which sclk has just returned to the idle level. The two strobes are never high together.
- R6: While xfer_run is low, sclk follows cpol one clock later, the half-period count restarts, and no strobe is issued.
- R7: A control write made while xfer_run is high does not change the running period. It takes effect on the first clock at which xfer_run is low.
- R8: The first sclk edge of a transfer comes on the H-th clock at which xfer_run is sampled high, where H is the half period set by R2 or R3.
- R9: A control write made while xfer_run is low takes effect on the same clock edge, so a transfer that starts on the next cycle already uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 13 | Control word: bits 7:0 linear count n, bits 11:8 exponent m, bit 12 mode select (1 = linear) |
| xfer_run | input | 1 | High while the shift engine runs a transfer |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sclk_lead | output | 1 | One-cycle strobe with each edge leaving the idle level |
| sclk_trail | output | 1 | One-cycle strobe with each edge returning to the idle level |

## Verification
Two things can happen in the same cycle: a control write, and a running serial clock that is partway through a half period. They collide when ctl_wr is pulsed on the cycle a leading strobe appears during a transfer. The bench then checks that the following edges keep the old spacing, and that the new spacing appears only after xfer_run has dropped and risen again. A second collision is a write on the last idle cycle before a transfer starts. That transfer must already run at the newly written rate.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  // Control word layout; software encodes divisors into these positions.
  localparam int LIN_W   = 8;
  localparam int EXP_W   = 4;
  localparam int CTL_W   = LIN_W + EXP_W + 1;
  localparam int SEL_BIT = LIN_W + EXP_W;

  // Width able to hold the largest half period of either mode.
  localparam int LIN_HALF_W = LIN_W + 1;
  localparam int EXP_HALF_W = (1 << EXP_W);
  localparam int HALF_W     = (LIN_HALF_W > EXP_HALF_W) ? LIN_HALF_W : EXP_HALF_W;

  typedef struct packed {
    logic             lin_sel;
    logic [EXP_W-1:0] exp_m;
    logic [LIN_W-1:0] lin_n;
  } ctl_t;

  // Half period in module clocks for a control word.
  function automatic logic [HALF_W-1:0] half_len(input ctl_t c);
    logic [HALF_W-1:0] h;
    if (c.lin_sel) begin
      h = HALF_W'(c.lin_n) + HALF_W'(1);
    end else begin
      h = HALF_W'(1) << c.exp_m;
    end
    return h;
  endfunction

  // Count value at which a half period completes.
  function automatic logic [HALF_W-1:0] last_count(input logic [HALF_W-1:0] h);
    return h - HALF_W'(1);
  endfunction

endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg
  import sclkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ctl_t wr_data,
  input  logic hold,
  output ctl_t cfg_act
);

  ctl_t pend_q;
  ctl_t act_q;
  ctl_t pend_d;
  ctl_t act_d;

  always_comb begin
    pend_d = wr_en ? wr_data : pend_q;
    act_d  = act_q;
    if (!hold) begin
      act_d = pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign cfg_act = act_q;

endmodule

// File: rtl/sclkdiv_halfcnt.sv
module sclkdiv_halfcnt
  import sclkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              hit
);

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] cnt_d;
  logic              at_end;

  assign at_end = (cnt_q == last_count(half));
  assign hit    = run && at_end;

  always_comb begin
    if (!run || at_end) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sclkdiv_edge.sv
module sclkdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpol,
  input  logic hit,
  output logic sclk,
  output logic lead,
  output logic trail
);

  logic sclk_q;
  logic sclk_d;
  logic lead_q;
  logic trail_q;
  logic leaving;

  assign leaving = (sclk_q == cpol);

  always_comb begin
    if (!run) begin
      sclk_d = cpol;
    end else if (hit) begin
      sclk_d = ~sclk_q;
    end else begin
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_d;
      lead_q  <= run && hit && leaving;
      trail_q <= run && hit && !leaving;
    end
  end

  assign sclk  = sclk_q;
  assign lead  = lead_q;
  assign trail = trail_q;

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             xfer_run,
  input  logic             cpol,
  output logic             sclk,
  output logic             sclk_lead,
  output logic             sclk_trail
);

  ctl_t              cfg_act;
  logic [HALF_W-1:0] half_cycles;
  logic              half_hit;

  sclkdiv_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr),
    .wr_data (ctl_t'(ctl_wdata)),
    .hold    (xfer_run),
    .cfg_act (cfg_act)
  );

  assign half_cycles = half_len(cfg_act);

  sclkdiv_halfcnt u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (xfer_run),
    .half  (half_cycles),
    .hit   (half_hit)
  );

  sclkdiv_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (xfer_run),
    .cpol  (cpol),
    .hit   (half_hit),
    .sclk  (sclk),
    .lead  (sclk_lead),
    .trail (sclk_trail)
  );

endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk
  import sclkdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_run,
  input logic             cpol,
  input logic             sclk,
  input logic             sclk_lead,
  input logic             sclk_trail,
  input logic [CTL_W-1:0] cfg_act,
  input logic             half_hit
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_lead && sclk_trail)); // R5

  AST_LEAD_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_lead |-> (sclk != cpol) && (sclk != $past(sclk))); // R5

  AST_TRAIL_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_trail |-> (sclk == cpol) && (sclk != $past(sclk))); // R5

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xfer_run) |-> (sclk == $past(cpol)) && !sclk_lead && !sclk_trail); // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xfer_run) |-> $stable(cfg_act)); // R7

  AST_TOGGLE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_run) && (sclk != $past(sclk))) |-> $past(half_hit)); // R2

endmodule

bind sclk_rate_gen sclk_rate_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_run   (xfer_run),
  .cpol       (cpol),
  .sclk       (sclk),
  .sclk_lead  (sclk_lead),
  .sclk_trail (sclk_trail),
  .cfg_act    (cfg_act),
  .half_hit   (half_hit)
);

// File: tb/sclk_rate_gen_test.sv
module sclk_rate_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [12:0] ctl_wdata = '0;
  logic        xfer_run = 1'b0;
  logic        cpol = 1'b0;
  logic        sclk;
  logic        sclk_lead;
  logic        sclk_trail;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sclk_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .xfer_run(xfer_run), .cpol(cpol), .sclk(sclk),
    .sclk_lead(sclk_lead), .sclk_trail(sclk_trail)
  );

  // Behavioural reference model
  int m_pend = 0;
  int m_act = 0;
  int m_cnt = 0;
  bit m_sclk = 0;
  bit m_lead = 0;
  bit m_trail = 0;
  bit m_idle = 1;

  function automatic int half_of(input int w);
    int h;
    if (((w >> 12) & 1) == 1) begin
      h = (w & 255) + 1;
    end else begin
      h = 1;
      for (int i = 0; i < ((w >> 8) & 15); i++) h = h * 2;
    end
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_cnt = 0;
      m_sclk = 0; m_lead = 0; m_trail = 0; m_idle = 1;
    end else begin
      int nxt_pend;
      nxt_pend = ctl_wr ? int'(ctl_wdata) : m_pend;
      m_lead = 0;
      m_trail = 0;
      m_idle = !xfer_run;
      if (!xfer_run) begin
        m_act = nxt_pend;
        m_cnt = 0;
        m_sclk = cpol;
      end else if (m_cnt == half_of(m_act) - 1) begin
        m_cnt = 0;
        m_sclk = !m_sclk;
        if (m_sclk != cpol) m_lead = 1;
        else m_trail = 1;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_pend = nxt_pend;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      if (m_idle) tg = "R6";
      else if (((m_act >> 12) & 1) == 1) tg = "R2";
      else tg = "R3";
      check(tg, int'(sclk), int'(m_sclk));
      check("R5 lead", int'(sclk_lead), int'(m_lead));
      check("R5 trail", int'(sclk_trail), int'(m_trail));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic write_cfg(input logic [12:0] w);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // Counts negedges until sclk_lead is seen
  task automatic wait_lead(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sclk_lead && n < 5000);
  endtask

  task automatic stop_run();
    xfer_run = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Starts a transfer on the current negedge and measures first edge and period
  task automatic measure(input int h, input string tag);
    int n;
    xfer_run = 1'b1;
    wait_lead(n);
    check({tag, " R8 first edge"}, n, h);
    wait_lead(n);
    check({tag, " period"}, n, 2 * h);
    wait_lead(n);
    check({tag, " period"}, n, 2 * h);
    stop_run();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 sclk", int'(sclk), 0);
    check("R1 lead", int'(sclk_lead), 0);
    check("R1 trail", int'(sclk_trail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Idle follows cpol
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 idle high", int'(sclk), 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 idle low", int'(sclk), 0);

    // Linear n=0
    write_cfg(13'h1000);
    measure(1, "R4");
    // Linear n=5
    write_cfg(13'h1005);
    measure(6, "R2");
    // Exponential m=0 and m=3
    write_cfg(13'h0000);
    measure(1, "R3");
    write_cfg(13'h0300);
    measure(8, "R3");
    // Same fields, mode bit decides
    write_cfg(13'h1301);
    measure(2, "R3 sel lin");
    write_cfg(13'h0301);
    measure(8, "R3 sel exp");
    // cpol high, exponential m=2
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    write_cfg(13'h0200);
    measure(4, "R5 cpol1");
    cpol = 1'b0;
    repeat (2) @(negedge clk);

    // Write during a transfer is deferred
    write_cfg(13'h1003);
    xfer_run = 1'b1;
    wait_lead(n);
    check("R7 first", n, 4);
    ctl_wr = 1'b1;
    ctl_wdata = 13'h1009;
    @(negedge clk);
    ctl_wr = 1'b0;
    wait_lead(n);
    check("R7 kept period", n + 1, 8);
    wait_lead(n);
    check("R7 kept period", n, 8);
    stop_run();
    measure(10, "R7 applied");

    // Write on the last idle cycle, run on the next
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = 13'h0100;
    @(negedge clk);
    ctl_wr = 1'b0;
    measure(2, "R9");

    // Reset in the middle of a transfer
    write_cfg(13'h1002);
    xfer_run = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    xfer_run = 1'b0;
    @(negedge clk);
    check("R1 mid sclk", int'(sclk), 0);
    check("R1 mid lead", int'(sclk_lead) | int'(sclk_trail), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    measure(1, "R1 cleared cfg");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule